// File: doc/BRIEF.md
# UART Modem-Control Loopback Unit

This unit sits between a UART's control registers and its receive path. It decides what the modem status flags show, keeps the four modem status interrupt bits, and chooses which characters and break markers are pushed into the receive FIFO. With loopback off, the flags follow the external modem input pins after a synchronizer, and received characters and break events from the line side go to the FIFO.

With loopback on, the four software-driven control outputs are cross-mapped onto the four status flags. The interrupt bits are rebuilt from the mapped values on every control write. Characters written for transmission are fed back into the receive FIFO, and so is a break marker when the send-break bit rises. Line-side input is dropped while loopback is on.

The receive FIFO accepts one entry per cycle. When a character and a break arrive in the same cycle, the character goes first and the break is held for the next free cycle. Flow control driven by hardware is handled elsewhere.

Top module: `uart_mdm_loop`

## Requirements
- R1: With loopback on, the flag vector `ms_flags` holds ring indicator = out2 (bit 0), clear-to-send = rts (bit 1), carrier detect = out1 (bit 2) and data-set-ready = dtr (bit 3).
- R2: The mapping takes effect in the cycle after any control write whose loopback bit is 1, including the write that first turns loopback on.
- R3: On such a write, `ms_int` is cleared and then rebuilt, so it equals the mapped vector of R1. Bits set before the write do not survive.
- R4: A control write whose loopback bit is 0 leaves `ms_int` unchanged. In the following cycle the flags show the synchronized pins again.
- R5: With loopback off, each modem pin reaches `ms_flags` through SYNC_STAGES flops (default 2). A change is not visible after one clock edge and is visible after two. The pin vector uses the bit order of R1.
- R6: With loopback on, a transmit write produces, one cycle later, a one-cycle push carrying the same data with the break flag low.
- R7: With loopback on, line-side characters and break events produce no push.
- R8: With loopback on, a 0-to-1 change of the send-break bit produces a one-cycle push with the break flag high and all-zero data. A write that keeps the bit at 1 or clears it pushes nothing, and so does a rise while loopback is off.
- R9: With loopback off, a line-side character is pushed one cycle later and a line-side break is pushed as a break entry, while transmit writes push nothing.
- R10: When a character and a break are due in the same cycle, the character is pushed first and the break in the next cycle.
- R11: After reset, flags and interrupt bits are zero and no push is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_lb | input | 1 | Loopback enable field of the written value |
| ctl_out2 | input | 1 | User output 2 field |
| ctl_out1 | input | 1 | User output 1 field |
| ctl_rts | input | 1 | Request-to-send field |
| ctl_dtr | input | 1 | Data-terminal-ready field |
| lcr_wr | input | 1 | Line control write strobe |
| lcr_brk | input | 1 | Send-break field of the written value |
| tx_wr | input | 1 | Transmit data write strobe |
| tx_data | input | DW | Transmit data |
| ext_rx_valid | input | 1 | Line-side character received |
| ext_rx_data | input | DW | Line-side character |
| ext_brk | input | 1 | Line-side break event |
| mdm_pins | input | 4 | Asynchronous modem pins {dsr, dcd, cts, ri} |
| ms_flags | output | 4 | Modem status flags {dsr, dcd, cts, ri} |
| ms_int | output | 4 | Modem status interrupt bits {dsr, dcd, cts, ri} |
| rx_push | output | 1 | Receive FIFO push request |
| rx_push_data | output | DW | Data to push |
| rx_push_brk | output | 1 | Entry is a break marker |

## Verification
A wrong loopback state shows at `ms_flags` in the cycle after the control write. The flags then show pins where mapped bits belong, or the other way round. A wrong mapping or a failed clear of the interrupt bits shows at `ms_int` after the same single cycle. The sweep over all sixteen output patterns catches any swapped or stuck lane. Push mistakes are visible one cycle after the stimulus: a leaked line-side character, a missing looped character, a lost or repeated break marker, or a break pushed ahead of the character it should follow.

// File: rtl/mlb_pkg.sv
package mlb_pkg;
   // modem lane order, bit 0 upward: ri, cts, dcd, dsr
   typedef struct packed {
      logic dsr;
      logic dcd;
      logic cts;
      logic ri;
   } mdm_t;

   localparam int MDM_W = $bits(mdm_t);

   function automatic mdm_t route_ctl(input logic out2, input logic out1,
                                      input logic rts, input logic dtr);
      mdm_t m;
      m.ri  = out2;
      m.dcd = out1;
      m.cts = rts;
      m.dsr = dtr;
      return m;
   endfunction
endpackage

// File: rtl/mlb_sync.sv
module mlb_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mlb_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               chain[s] <= '0;
            else if (s == 0)
               chain[s] <= d;
            else
               chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mlb_map.sv
module mlb_map
   import mlb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_wr,
   input  logic ctl_lb,
   input  logic ctl_out2,
   input  logic ctl_out1,
   input  logic ctl_rts,
   input  logic ctl_dtr,
   output logic lb_q,
   output mdm_t lb_flags,
   output mdm_t int_q
);
   mdm_t routed;
   mdm_t int_rebuilt;
   logic upd;

   assign routed = route_ctl(ctl_out2, ctl_out1, ctl_rts, ctl_dtr);
   assign upd    = ctl_wr & ctl_lb;

   // every lane is cleared first, then set from the routed value
   always_comb begin
      int_rebuilt = '0;
      if (routed.dsr) int_rebuilt.dsr = 1'b1;
      if (routed.dcd) int_rebuilt.dcd = 1'b1;
      if (routed.cts) int_rebuilt.cts = 1'b1;
      if (routed.ri)  int_rebuilt.ri  = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lb_q     <= 1'b0;
         lb_flags <= '0;
         int_q    <= '0;
      end else begin
         if (ctl_wr) lb_q <= ctl_lb;
         if (upd) begin
            lb_flags <= routed;
            int_q    <= int_rebuilt;
         end
      end
   end
endmodule

// File: rtl/mlb_rxsel.sv
module mlb_rxsel #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lb_q,
   input  logic          tx_wr,
   input  logic [DW-1:0] tx_data,
   input  logic          ext_rx_valid,
   input  logic [DW-1:0] ext_rx_data,
   input  logic          ext_brk,
   input  logic          lcr_wr,
   input  logic          lcr_brk,
   output logic          push,
   output logic [DW-1:0] push_data,
   output logic          push_brk
);
   logic          brk_q;
   logic          brk_pend;
   logic          brk_rise;
   logic          chr_req;
   logic [DW-1:0] chr_data;
   logic          brk_req;
   logic          n_push;
   logic [DW-1:0] n_data;
   logic          n_brk;
   logic          n_pend;

   assign brk_rise = lcr_wr & lcr_brk & ~brk_q;
   assign chr_req  = lb_q ? tx_wr : ext_rx_valid;
   assign chr_data = lb_q ? tx_data : ext_rx_data;
   assign brk_req  = lb_q ? brk_rise : ext_brk;

   always_comb begin
      n_push = 1'b0;
      n_data = '0;
      n_brk  = 1'b0;
      n_pend = brk_pend;
      if (chr_req) begin
         n_push = 1'b1;
         n_data = chr_data;
         n_pend = brk_pend | brk_req;
      end else if (brk_pend | brk_req) begin
         n_push = 1'b1;
         n_brk  = 1'b1;
         n_pend = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brk_q     <= 1'b0;
         brk_pend  <= 1'b0;
         push      <= 1'b0;
         push_data <= '0;
         push_brk  <= 1'b0;
      end else begin
         if (lcr_wr) brk_q <= lcr_brk;
         brk_pend  <= n_pend;
         push      <= n_push;
         push_data <= n_data;
         push_brk  <= n_brk;
      end
   end
endmodule

// File: rtl/uart_mdm_loop.sv
module uart_mdm_loop
   import mlb_pkg::*;
#(
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_wr,
   input  logic          ctl_lb,
   input  logic          ctl_out2,
   input  logic          ctl_out1,
   input  logic          ctl_rts,
   input  logic          ctl_dtr,
   input  logic          lcr_wr,
   input  logic          lcr_brk,
   input  logic          tx_wr,
   input  logic [DW-1:0] tx_data,
   input  logic          ext_rx_valid,
   input  logic [DW-1:0] ext_rx_data,
   input  logic          ext_brk,
   input  logic [3:0]    mdm_pins,
   output logic [3:0]    ms_flags,
   output logic [3:0]    ms_int,
   output logic          rx_push,
   output logic [DW-1:0] rx_push_data,
   output logic          rx_push_brk
);
   generate
      if (DW < 1) begin : g_bad_dw
         $error("uart_mdm_loop: DW must be positive");
      end
      if (MDM_W != 4) begin : g_bad_mdm
         $error("uart_mdm_loop: modem vector must be four lanes");
      end
   endgenerate

   logic [MDM_W-1:0] pins_s;
   logic             lb_q;
   mdm_t             lb_flags;
   mdm_t             int_q;

   mlb_sync #(.W(MDM_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(mdm_pins), .q(pins_s)
   );

   mlb_map u_map (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_lb(ctl_lb),
      .ctl_out2(ctl_out2), .ctl_out1(ctl_out1), .ctl_rts(ctl_rts),
      .ctl_dtr(ctl_dtr), .lb_q(lb_q), .lb_flags(lb_flags), .int_q(int_q)
   );

   mlb_rxsel #(.DW(DW)) u_rx (
      .clk(clk), .rst_n(rst_n), .lb_q(lb_q), .tx_wr(tx_wr), .tx_data(tx_data),
      .ext_rx_valid(ext_rx_valid), .ext_rx_data(ext_rx_data), .ext_brk(ext_brk),
      .lcr_wr(lcr_wr), .lcr_brk(lcr_brk), .push(rx_push),
      .push_data(rx_push_data), .push_brk(rx_push_brk)
   );

   assign ms_flags = lb_q ? lb_flags : pins_s;
   assign ms_int   = int_q;
endmodule

// File: rtl/uart_mdm_loop_chk.sv
module uart_mdm_loop_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ctl_wr,
   input logic          ctl_lb,
   input logic          ctl_out2,
   input logic          ctl_out1,
   input logic          ctl_rts,
   input logic          ctl_dtr,
   input logic          tx_wr,
   input logic [DW-1:0] tx_data,
   input logic          lb_q,
   input logic [3:0]    ms_flags,
   input logic [3:0]    ms_int,
   input logic          rx_push,
   input logic [DW-1:0] rx_push_data,
   input logic          rx_push_brk
);
   AST_FLAGS_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_lb) |=> ms_flags == {$past(ctl_dtr), $past(ctl_out1), $past(ctl_rts), $past(ctl_out2)}); // R1
   AST_LOOP_STATE_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_lb) |=> lb_q); // R2
   AST_INT_REBUILT: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_lb) |=> ms_int == {$past(ctl_dtr), $past(ctl_out1), $past(ctl_rts), $past(ctl_out2)}); // R3
   AST_INT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctl_wr && ctl_lb) |=> $stable(ms_int)); // R4
   AST_TX_LOOPED: assert property (@(posedge clk) disable iff (!rst_n)
      (lb_q && tx_wr) |=> (rx_push && !rx_push_brk && rx_push_data == $past(tx_data))); // R6
   AST_BRK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push_brk |-> (rx_push && rx_push_data == '0)); // R8
endmodule

bind uart_mdm_loop uart_mdm_loop_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_lb(ctl_lb),
   .ctl_out2(ctl_out2), .ctl_out1(ctl_out1), .ctl_rts(ctl_rts), .ctl_dtr(ctl_dtr),
   .tx_wr(tx_wr), .tx_data(tx_data), .lb_q(lb_q), .ms_flags(ms_flags),
   .ms_int(ms_int), .rx_push(rx_push), .rx_push_data(rx_push_data),
   .rx_push_brk(rx_push_brk)
);

// File: tb/tb_uart_mdm_loop.sv
module tb_uart_mdm_loop;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_wr = 0, ctl_lb = 0, ctl_out2 = 0, ctl_out1 = 0, ctl_rts = 0, ctl_dtr = 0;
   logic lcr_wr = 0, lcr_brk = 0, tx_wr = 0, ext_rx_valid = 0, ext_brk = 0;
   logic [DW-1:0] tx_data = '0, ext_rx_data = '0;
   logic [3:0] mdm_pins = '0;
   logic [3:0] ms_flags, ms_int;
   logic rx_push, rx_push_brk;
   logic [DW-1:0] rx_push_data;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   uart_mdm_loop #(.DW(DW), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_lb(ctl_lb),
      .ctl_out2(ctl_out2), .ctl_out1(ctl_out1), .ctl_rts(ctl_rts), .ctl_dtr(ctl_dtr),
      .lcr_wr(lcr_wr), .lcr_brk(lcr_brk), .tx_wr(tx_wr), .tx_data(tx_data),
      .ext_rx_valid(ext_rx_valid), .ext_rx_data(ext_rx_data), .ext_brk(ext_brk),
      .mdm_pins(mdm_pins), .ms_flags(ms_flags), .ms_int(ms_int),
      .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_push_brk(rx_push_brk)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // v bit order: 0 out2, 1 rts, 2 out1, 3 dtr -> expected flags equal v
   task automatic ctl_write(input bit lb, input logic [3:0] v);
      @(negedge clk);
      ctl_wr = 1; ctl_lb = lb;
      ctl_out2 = v[0]; ctl_rts = v[1]; ctl_out1 = v[2]; ctl_dtr = v[3];
      @(negedge clk);
      ctl_wr = 0;
   endtask

   task automatic chk_push(input string req, input bit p, input bit b, input int d);
      chk(rx_push == p, req, rx_push, p);
      if (p) begin
         chk(rx_push_brk == b, req, rx_push_brk, b);
         chk(rx_push_data == d[DW-1:0], req, rx_push_data, d);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(ms_flags == 4'h0, "R11", ms_flags, 0);
      chk(ms_int == 4'h0, "R11", ms_int, 0);
      chk(rx_push == 1'b0, "R11", rx_push, 0);
      rst_n = 1'b1;

      // R5: pin sweep with loopback off, two-stage latency
      for (int p = 0; p < 16; p++) begin
         logic [3:0] prev;
         prev = ms_flags;
         mdm_pins = p[3:0];
         @(negedge clk);
         if (prev != p[3:0]) chk(ms_flags == prev, "R5", ms_flags, prev);
         @(negedge clk);
         chk(ms_flags == p[3:0], "R5", ms_flags, p);
      end
      mdm_pins = 4'h5;
      repeat (3) @(negedge clk);

      // R1 R2 R3: sweep all output patterns with loopback on
      for (int v = 0; v < 16; v++) begin
         ctl_write(1'b1, v[3:0]);
         chk(ms_flags == v[3:0], "R1", ms_flags, v);
         chk(ms_int == v[3:0], "R3", ms_int, v);
      end
      // R2: write that enables loopback applies at once (from off state)
      ctl_write(1'b0, 4'h0);
      chk(ms_flags == 4'h5, "R4", ms_flags, 5);
      chk(ms_int == 4'hF, "R4", ms_int, 15);
      ctl_write(1'b1, 4'hA);
      chk(ms_flags == 4'hA, "R2", ms_flags, 10);
      chk(ms_int == 4'hA, "R3", ms_int, 10);
      // R4: writes with loopback off leave interrupts alone
      for (int v = 0; v < 16; v++) begin
         ctl_write(1'b0, v[3:0]);
         chk(ms_int == 4'hA, "R4", ms_int, 10);
         chk(ms_flags == 4'h5, "R4", ms_flags, 5);
      end

      // R9: loopback off, external input pushed, tx ignored
      for (int d = 1; d < 256; d += 37) begin
         @(negedge clk); ext_rx_valid = 1; ext_rx_data = d[7:0];
         @(negedge clk); ext_rx_valid = 0;
         chk_push("R9", 1, 0, d);
      end
      @(negedge clk); ext_brk = 1;
      @(negedge clk); ext_brk = 0;
      chk_push("R9", 1, 1, 0);
      @(negedge clk); tx_wr = 1; tx_data = 8'h3C;
      @(negedge clk); tx_wr = 0;
      chk_push("R9", 0, 0, 0);
      // R8: break rise while loopback off pushes nothing
      @(negedge clk); lcr_wr = 1; lcr_brk = 1;
      @(negedge clk); lcr_wr = 0;
      chk_push("R8", 0, 0, 0);
      @(negedge clk); lcr_wr = 1; lcr_brk = 0;
      @(negedge clk); lcr_wr = 0;

      // loopback on
      ctl_write(1'b1, 4'h0);
      // R6
      for (int d = 0; d < 256; d += 51) begin
         @(negedge clk); tx_wr = 1; tx_data = d[7:0];
         @(negedge clk); tx_wr = 0;
         chk_push("R6", 1, 0, d);
      end
      @(negedge clk);
      chk_push("R6", 0, 0, 0);
      // R7
      @(negedge clk); ext_rx_valid = 1; ext_rx_data = 8'h77;
      @(negedge clk); ext_rx_valid = 0; ext_brk = 1;
      chk_push("R7", 0, 0, 0);
      @(negedge clk); ext_brk = 0;
      chk_push("R7", 0, 0, 0);
      // R8: rise pushes, hold and clear push nothing
      @(negedge clk); lcr_wr = 1; lcr_brk = 1;
      @(negedge clk); lcr_wr = 0;
      chk_push("R8", 1, 1, 0);
      @(negedge clk); lcr_wr = 1; lcr_brk = 1;
      @(negedge clk); lcr_wr = 0;
      chk_push("R8", 0, 0, 0);
      @(negedge clk); lcr_wr = 1; lcr_brk = 0;
      @(negedge clk); lcr_wr = 0;
      chk_push("R8", 0, 0, 0);
      // R10: char and break in the same cycle
      @(negedge clk); lcr_wr = 1; lcr_brk = 1; tx_wr = 1; tx_data = 8'hC3;
      @(negedge clk); lcr_wr = 0; tx_wr = 0;
      chk_push("R10", 1, 0, 8'hC3);
      @(negedge clk);
      chk_push("R10", 1, 1, 0);
      @(negedge clk);
      chk_push("R10", 0, 0, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule